// File: doc/BRIEF.md
# I2S Serial Transceiver with Loopback

This block is a single-clock I2S master. It turns 32-bit parallel words into a serial stream on a transmit path and rebuilds 32-bit words from a serial stream on a receive path. Each path makes its own bit clock and word-select line from the audio clock. Each path has its own divider, so transmit and receive may run at different bit rates. A word carries the left channel in bits 31:16 and the right channel in bits 15:0. Bits go out and come in MSB first, in the usual I2S framing, where the data lags the word-select change by one bit clock.

The transmitter asks for a new word once per frame with a one-cycle `tx_ready` pulse. If no word is offered at that moment, it sends a silent (all-zero) frame. The receiver raises `rx_valid` for one cycle when a complete word has been captured. Each direction has its own enable. A loopback input feeds the transmitter's outgoing serial bit into the receiver in place of the external data pin, for self-test.

Top module: `i2s_xcvr`

## Requirements
- R1: Each direction's bit clock has a period of exactly 2*N audio-clock cycles, high for N cycles and low for N cycles. N is that direction's own divisor, `tx_div` or `rx_div`. The first rising edge comes N cycles after the direction is enabled.
- R2: A divisor value of 0 behaves exactly like a divisor of 1.
- R3: Word select changes only together with a falling edge of its own bit clock. It is low (left) and high (right) by slot. Counting falling edges after enable from 1, slot = (count-1) mod 32. Word select is 1 after a fall into slots 15 to 30 and 0 in all other slots, so it toggles every 16 bit clocks.
- R4: `tx_sd` changes only on a falling edge of `tx_sclk`. In slot s it carries bit 31-s of the current frame's word (MSB first, left half first).
- R5: `tx_ready` is a one-cycle pulse that occurs only while transmit is enabled, once per 32 bit clocks, in the cycle just before the falling edge that starts slot 0. The word on `tx_data` is taken when `tx_valid` is high in that cycle.
- R6: If `tx_valid` is low during the `tx_ready` cycle, the frame carries the all-zero word.
- R7: The receiver samples its data input on each rising edge of `rx_sclk`. After slot 31 is sampled, it presents the word on `rx_data` with a one-cycle `rx_valid` pulse. The partial frame before the first slot 0 after enable is discarded.
- R8: With `loopback` high, the receiver takes `tx_sd` and ignores `rx_sd`. With equal divisors and simultaneous enables, the words received are the words sent, in order.
- R9: While a direction's enable is low, its bit clock and word select (and `tx_sd`) are low from the next cycle on, and no `tx_ready` or `rx_valid` pulse occurs. Enabling it again restarts framing from the lead-in slot.
- R10: Either direction runs while the other is disabled. The disabled direction's clock stays low throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Audio clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit direction enable |
| rx_en | input | 1 | Receive direction enable |
| loopback | input | 1 | Route `tx_sd` into the receiver |
| tx_div | input | DIVW (7) | Transmit divisor N |
| rx_div | input | DIVW (7) | Receive divisor N |
| tx_data | input | WORDW (32) | Word to transmit |
| tx_valid | input | 1 | `tx_data` holds a word |
| tx_ready | output | 1 | Word taken this cycle when `tx_valid` is high |
| tx_sclk | output | 1 | Transmit bit clock |
| tx_ws | output | 1 | Transmit word select |
| tx_sd | output | 1 | Transmit serial data |
| rx_data | output | WORDW (32) | Last received word |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` is new |
| rx_sclk | output | 1 | Receive bit clock |
| rx_ws | output | 1 | Receive word select |
| rx_sd | input | 1 | External receive serial data |

## Verification
The bound checker watches three things on every cycle. Word select and transmit data may move only with a falling bit-clock edge. Disabled paths must stay quiet. `tx_ready` and `rx_valid` must be single-cycle pulses tied to the proper clock edge. The bench scenarios cover what needs arithmetic over whole frames: the 2*N period for a sweep of divisors including 0 and 127, the slot-by-slot word-select and MSB-first bit order, silent frames when no word is offered, and exact word recovery. Word recovery is shown both through loopback (with `rx_sd` toggling as noise) and from a bench-driven external stream at a different receive rate.

// File: rtl/i2s_xcvr.sv
module i2s_xcvr #(
  parameter int DIVW  = 7,
  parameter int WORDW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             loopback,
  input  logic [DIVW-1:0]  tx_div,
  input  logic [DIVW-1:0]  rx_div,
  input  logic [WORDW-1:0] tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             tx_sclk,
  output logic             tx_ws,
  output logic             tx_sd,
  output logic [WORDW-1:0] rx_data,
  output logic             rx_valid,
  output logic             rx_sclk,
  output logic             rx_ws,
  input  logic             rx_sd
);

  localparam int HALF = WORDW / 2;
  localparam int BCW  = $clog2(WORDW);
  localparam logic [BCW-1:0] LAST = BCW'(WORDW - 1);

  function automatic logic [BCW-1:0] next_slot(input logic [BCW-1:0] b);
    return (b == LAST) ? '0 : b + 1'b1;
  endfunction

  function automatic logic right_slot(input logic [BCW-1:0] b);
    return (b >= BCW'(HALF - 1)) && (b <= BCW'(WORDW - 2));
  endfunction

  // transmit path
  logic [DIVW-1:0]  tx_n, tx_cnt;
  logic [BCW-1:0]   tx_bc;
  logic [WORDW-1:0] tx_sh;
  logic             tx_tick, tx_fall;

  assign tx_n     = (tx_div == '0) ? DIVW'(1) : tx_div;
  assign tx_tick  = tx_cnt >= tx_n - 1'b1;
  assign tx_fall  = tx_tick & tx_sclk;
  assign tx_ready = tx_en & tx_fall & (tx_bc == LAST);
  assign tx_sd    = tx_sh[WORDW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_cnt  <= '0;
      tx_sclk <= 1'b0;
      tx_ws   <= 1'b0;
      tx_bc   <= LAST;
      tx_sh   <= '0;
    end else if (!tx_en) begin
      tx_cnt  <= '0;
      tx_sclk <= 1'b0;
      tx_ws   <= 1'b0;
      tx_bc   <= LAST;
      tx_sh   <= '0;
    end else begin
      tx_cnt <= tx_tick ? '0 : tx_cnt + 1'b1;
      if (tx_tick) tx_sclk <= ~tx_sclk;
      if (tx_fall) begin
        tx_bc <= next_slot(tx_bc);
        tx_ws <= right_slot(next_slot(tx_bc));
        tx_sh <= (tx_bc == LAST) ? (tx_valid ? tx_data : '0)
                                 : {tx_sh[WORDW-2:0], 1'b0};
      end
    end
  end

  // receive path
  logic [DIVW-1:0]  rx_n, rx_cnt;
  logic [BCW-1:0]   rx_bc;
  logic [WORDW-1:0] rx_sr;
  logic             rx_tick, rx_fall, rx_rise, rx_din, rx_primed;

  assign rx_n    = (rx_div == '0) ? DIVW'(1) : rx_div;
  assign rx_tick = rx_cnt >= rx_n - 1'b1;
  assign rx_fall = rx_tick & rx_sclk;
  assign rx_rise = rx_tick & ~rx_sclk;
  assign rx_din  = loopback ? tx_sd : rx_sd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt    <= '0;
      rx_sclk   <= 1'b0;
      rx_ws     <= 1'b0;
      rx_bc     <= LAST;
      rx_sr     <= '0;
      rx_primed <= 1'b0;
      rx_valid  <= 1'b0;
      rx_data   <= '0;
    end else if (!rx_en) begin
      rx_cnt    <= '0;
      rx_sclk   <= 1'b0;
      rx_ws     <= 1'b0;
      rx_bc     <= LAST;
      rx_primed <= 1'b0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      rx_cnt   <= rx_tick ? '0 : rx_cnt + 1'b1;
      if (rx_tick) rx_sclk <= ~rx_sclk;
      if (rx_fall) begin
        rx_bc <= next_slot(rx_bc);
        rx_ws <= right_slot(next_slot(rx_bc));
      end
      if (rx_rise) begin
        rx_sr <= {rx_sr[WORDW-2:0], rx_din};
        if (rx_bc == '0) rx_primed <= 1'b1;
        if (rx_bc == LAST && rx_primed) begin
          rx_data  <= {rx_sr[WORDW-2:0], rx_din};
          rx_valid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/i2s_xcvr_chk.sv
module i2s_xcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic rx_en,
  input logic tx_sclk,
  input logic tx_ws,
  input logic tx_sd,
  input logic tx_ready,
  input logic rx_sclk,
  input logic rx_ws,
  input logic rx_valid
);

  // R9
  tx_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> !tx_sclk && !tx_ws && !tx_sd);

  // R9
  rx_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_sclk && !rx_ws && !rx_valid);

  // R3
  tx_ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_en) && (tx_ws != $past(tx_ws)) |-> $fell(tx_sclk));

  // R3
  rx_ws_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rx_en) && (rx_ws != $past(rx_ws)) |-> $fell(rx_sclk));

  // R4
  tx_sd_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_en) && (tx_sd != $past(tx_sd)) |-> $fell(tx_sclk));

  // R5
  tx_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> tx_en && tx_sclk);

  // R5
  tx_ready_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready && !tx_sclk);

  // R7
  rx_valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $rose(rx_sclk) && $past(rx_en));

  // R7
  rx_valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

endmodule

bind i2s_xcvr i2s_xcvr_chk chk (.*);

// File: tb/i2s_xcvr_test.sv
`timescale 1ns/1ps
module i2s_xcvr_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_en = 1'b0, rx_en = 1'b0, loopback = 1'b0;
  logic [6:0]  tx_div = 7'd1, rx_div = 7'd1;
  logic [31:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready, tx_sclk, tx_ws, tx_sd;
  logic [31:0] rx_data;
  logic        rx_valid, rx_sclk, rx_ws;
  logic        rx_sd = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2s_xcvr uut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en), .loopback(loopback),
    .tx_div(tx_div), .rx_div(rx_div), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_sclk(tx_sclk), .tx_ws(tx_ws), .tx_sd(tx_sd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_sclk(rx_sclk), .rx_ws(rx_ws),
    .rx_sd(rx_sd)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic [31:0] pat(input int i, input int d);
    return 32'hA5C3_1E78 + 32'(i) * 32'h0101_0203 + 32'(d);
  endfunction

  function automatic logic [31:0] ext(input int i);
    return 32'h3C96_F00D ^ (32'(i) * 32'h9E37_79B9);
  endfunction

  task automatic run(input int td, input int rd, input bit lb, input bit te, input bit re,
                     input int nw, input int gap);
    logic [31:0] sent [0:15];
    int nsent = 0, nrecv = 0, widx = 0, cyc = 0;
    int tfalls = 0, rfalls = 0, trise = -1, rrise = -1;
    int slot, frame;
    bit pend = 0, ptx = 0, prx = 0, quiet_ok = 1, fin = 0;
    @(negedge clk);
    tx_div = 7'(td); rx_div = 7'(rd); loopback = lb;
    tx_data = pat(0, td); tx_valid = te && (gap != 0);
    rx_sd = 1'b0;
    tx_en = te; rx_en = re;
    while (!fin && cyc < 40000) begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        widx++;
        tx_data = pat(widx, td);
        tx_valid = (widx != gap);
        pend = 0;
      end
      if (tx_ready) begin
        if (nsent < 16) sent[nsent] = tx_valid ? tx_data : 32'h0;
        nsent++;
        pend = 1;
      end
      if (!te && (tx_sclk || tx_ready)) quiet_ok = 0;
      if (!re && (rx_sclk || rx_valid)) quiet_ok = 0;
      // transmit bit clock and framing
      if (tx_sclk && !ptx) begin
        if (trise >= 0) chk(cyc - trise == 2 * eff(td), "R1/R2 tx period", 32'(cyc - trise), 32'(2 * eff(td)));
        trise = cyc;
      end
      if (!tx_sclk && ptx) begin
        tfalls++;
        slot = (tfalls - 1) % 32;
        chk(tx_ws == (slot >= 15 && slot <= 30), "R3 tx_ws", 32'(tx_ws), 32'(slot >= 15 && slot <= 30));
        if (nsent > 0 && nsent <= 16)
          chk(tx_sd == sent[nsent-1][31-slot], "R4 tx_sd bit", 32'(tx_sd), 32'(sent[nsent-1][31-slot]));
      end
      // receive bit clock, framing and external stream
      if (rx_sclk && !prx) begin
        if (rrise >= 0) chk(cyc - rrise == 2 * eff(rd), "R1/R2 rx period", 32'(cyc - rrise), 32'(2 * eff(rd)));
        rrise = cyc;
      end
      if (!rx_sclk && prx) begin
        rfalls++;
        slot = (rfalls - 1) % 32;
        frame = (rfalls - 1) / 32;
        chk(rx_ws == (slot >= 15 && slot <= 30), "R3 rx_ws", 32'(rx_ws), 32'(slot >= 15 && slot <= 30));
        if (!lb) rx_sd = ext(frame)[31-slot];
      end
      if (lb) rx_sd = cyc[0];
      if (rx_valid) begin
        if (lb) begin
          if (nrecv < nsent && nrecv < 16)
            chk(rx_data == sent[nrecv], "R7/R8/R6 loopback word", rx_data, sent[nrecv]);
          else
            chk(0, "R7 word before send", rx_data, 32'h0);
        end else begin
          chk(rx_data == ext(nrecv), "R7 external word", rx_data, ext(nrecv));
        end
        nrecv++;
      end
      ptx = tx_sclk;
      prx = rx_sclk;
      fin = re ? (nrecv >= nw) : (tfalls >= 32 * nw);
    end
    chk(fin, "R7 run completes", 32'(cyc), 32'(nw));
    chk(quiet_ok, "R10 disabled direction quiet", 32'(quiet_ok), 32'd1);
    if (te && !re) chk(nsent == nw, "R5 one ready per frame", 32'(nsent), 32'(nw));
    if (gap >= 0 && gap < nsent && gap < 16)
      chk(sent[gap] == 32'h0, "R6 silent frame", sent[gap], 32'h0);
    tx_en = 1'b0; rx_en = 1'b0; tx_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({tx_sclk, tx_ws, tx_sd, tx_ready} == 4'b0, "R9 tx idle low", 32'({tx_sclk, tx_ws, tx_sd, tx_ready}), 32'h0);
    chk({rx_sclk, rx_ws, rx_valid} == 3'b0, "R9 rx idle low", 32'({rx_sclk, rx_ws, rx_valid}), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tx_sclk, tx_ws, tx_sd, tx_ready, rx_sclk, rx_ws, rx_valid} == 7'b0,
        "R9 reset state", 32'({tx_sclk, tx_ws, tx_sd, tx_ready, rx_sclk, rx_ws, rx_valid}), 32'h0);
    run(0, 0, 1, 1, 1, 3, -1);
    run(1, 1, 1, 1, 1, 3, 1);
    run(3, 3, 1, 1, 1, 3, -1);
    run(5, 5, 1, 1, 1, 2, 0);
    run(2, 3, 0, 1, 1, 3, -1);
    run(4, 0, 0, 0, 1, 2, -1);
    run(6, 2, 0, 1, 0, 2, -1);
    run(127, 127, 1, 1, 1, 2, -1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule